// File: doc/BRIEF.md
# Parallel Augmented-Message CRC Engine

This block forms the frame check sequence of a cyclic redundancy code over a message that arrives as a stream of `DATA_W`-bit words, one word for each accepted clock. It is the word-wide form of the classic division register. The sender appends `CRC_W` zero bits to the message. After the message and the zero padding have been accepted from a cleared register, the register holds the remainder of the padded message divided by the generator polynomial. The same engine can serve as a receiver. If the message is followed by its own check sequence, the register ends at zero.

The generator is set by the parameter `POLY`, which is `CRC_W` bits wide. Bit `i` of `POLY` holds the coefficient of x^i, and the x^`CRC_W` term is implied. `POLY[0]` must be 1. `DATA_W` may be smaller than `CRC_W`, but it must divide it evenly. At elaboration the block raises the one-step transition matrix of the division register to the power `DATA_W`. Each accepted cycle then loads the register with that matrix applied to the old state, XORed with the incoming word placed in the lowest state bits. When `DATA_W` is 1 the block builds the plain shift-and-feedback form instead. The word's most significant bit is the earliest message bit. Framing, reflection, output inversion and non-zero seeds are left to the surrounding logic.

Top module: `crcp_engine`

## Requirements
- R1: While `clr` is high at a rising clock edge, `fcs` is zero after that edge. This holds whatever `valid` and `data` are.
- R2: While `clr` and `valid` are both low at an edge, `fcs` keeps its value, whatever `data` carries.
- R3: With `DATA_W` = 1, one accepted bit d updates the state x as follows: x0 becomes d XOR x(m-1), and xi becomes x(i-1) XOR (POLY[i] AND x(m-1)) for i from 1 to m-1.
- R4: With `DATA_W` > 1, one accepted word gives the same state as `DATA_W` serial steps of R3. The serial steps take bit `DATA_W`-1 first and bit 0 last, so widths 1, m/2 and m reach the same result on the same bit stream.
- R5: For `POLY` = 16'h8005 with m = w = 16, the rows of the transition matrix for x15, x14 and x13 are 16'hDFFF, 16'h3000 and 16'h1800. Bit c of a row is the coefficient of x_c. Column c can be seen at the ports: load the one-hot word with only bit c set into a cleared register, then accept one zero word, and `fcs` equals column c.
- R6: For `POLY` = 4'b1001 (x^4+x^3+1) with m = w = 4, the rows for x3, x2, x1 and x0 are 4'b0111, 4'b1100, 4'b1110 and 4'b1111. They are seen at the ports in the same way as in R5.
- R7: Start from a cleared register and accept the ASCII bytes "123456789" (0x31 to 0x39), then 16 zero bits. The result is 16'hFEE8 for `POLY` 16'h8005 and 16'h31C3 for `POLY` 16'h1021, both at width 8 and at width 1.
- R8: A message followed by its own check sequence, in place of the zero padding, leaves `fcs` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of the remainder register; has priority over `valid` |
| valid | input | 1 | Accept `data` on this edge |
| data | input | DATA_W | Message or padding word; bit DATA_W-1 is the earliest bit |
| fcs | output | CRC_W | Remainder register; holds the check sequence once the padding has been accepted |

## Verification
The matrix generator is checked with impulse words. One-hot words into a cleared register bring the columns of the matrix out at the ports. A power built one step short, or with its columns shifted the wrong way, gives the wrong columns and fails the known rows. Seeded random streams, with gaps in `valid` and occasional clears, are compared every cycle against a bit-serial model at widths 1, 8 and 16 for two polynomials. A reversed bit order inside the word, or a padding lane placed in the upper state bits, shows up as a divergence on the first word. The directed checks also include the standard check string, a receiver pass that must reach zero, and a clear asserted together with `valid`. That last case catches logic that lets a word through during a clear.

// File: rtl/crcp_pkg.sv
package crcp_pkg;

   // Structure picked for the next-state logic
   typedef enum logic [0:0] {
      STEP_SHIFT  = 1'b0,   // one bit per cycle, direct feedback form
      STEP_MATRIX = 1'b1    // w bits per cycle, w-th power of the step matrix
   } step_kind_e;

   function automatic step_kind_e pick_step(input int unsigned word_w);
      return (word_w == 1) ? STEP_SHIFT : STEP_MATRIX;
   endfunction

   // The word must be non-empty and must tile the register exactly
   function automatic bit widths_legal(input int unsigned crc_w,
                                       input int unsigned word_w);
      return (word_w >= 1) && (crc_w >= 2) && (word_w <= crc_w) &&
             ((crc_w % word_w) == 0);
   endfunction

endpackage

// File: rtl/crcp_word_embed.sv
// Places the incoming word in the lowest state positions and ties the
// remaining upper positions to zero.
module crcp_word_embed #(
   parameter int unsigned CRC_W  = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] word,
   output logic [CRC_W-1:0]  lane
);
   localparam int unsigned PAD_W = CRC_W - DATA_W;

   generate
      if (PAD_W == 0) begin : g_full
         assign lane = word;
      end else begin : g_padded
         assign lane = {{PAD_W{1'b0}}, word};
      end
   endgenerate
endmodule

// File: rtl/crcp_next_state.sv
// Combinational next state of the remainder register for one accepted word.
module crcp_next_state
   import crcp_pkg::*;
#(
   parameter int unsigned         CRC_W  = 16,
   parameter int unsigned         DATA_W = 8,
   parameter logic [CRC_W-1:0]    POLY   = 16'h8005
) (
   input  logic [CRC_W-1:0] cur,
   input  logic [CRC_W-1:0] lane,
   output logic [CRC_W-1:0] nxt
);
   localparam step_kind_e KIND = pick_step(DATA_W);

   // mat[r][c]: contribution of old state bit c to new state bit r
   typedef logic [CRC_W-1:0][CRC_W-1:0] mat_t;

   // Start from the one-step matrix, then raise it to the DATA_W-th power.
   // The feedback column of each new power is the previous power times the
   // polynomial column. Every other column is taken from its neighbour in
   // the previous power.
   function automatic mat_t build_power();
      mat_t acc;
      mat_t tmp;
      acc = '0;
      for (int r = 0; r < int'(CRC_W); r++) begin
         acc[r][CRC_W-1] = POLY[r];
         if (r > 0) acc[r][r-1] = 1'b1;
      end
      for (int i = 2; i <= int'(DATA_W); i++) begin
         for (int r = 0; r < int'(CRC_W); r++) begin
            tmp[r][CRC_W-1] = ^(acc[r] & POLY);
            for (int c = 0; c < int'(CRC_W) - 1; c++) begin
               tmp[r][c] = acc[r][c+1];
            end
         end
         acc = tmp;
      end
      return acc;
   endfunction

   generate
      if (KIND == STEP_SHIFT) begin : g_shift
         logic fb;
         assign fb     = cur[CRC_W-1];
         assign nxt[0] = lane[0] ^ fb;
         for (genvar r = 1; r < CRC_W; r++) begin : g_bit
            assign nxt[r] = cur[r-1] ^ (POLY[r] & fb) ^ lane[r];
         end
      end else begin : g_matrix
         localparam mat_t FW = build_power();
         for (genvar r = 0; r < CRC_W; r++) begin : g_row
            assign nxt[r] = (^(FW[r] & cur)) ^ lane[r];
         end
      end
   endgenerate
endmodule

// File: rtl/crcp_state_reg.sv
// Remainder register: synchronous clear first, then load on valid.
module crcp_state_reg #(
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             valid,
   input  logic [CRC_W-1:0] nxt,
   output logic [CRC_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (clr)        q <= '0;
      else if (valid) q <= nxt;
   end

   // Armed once the first clear has been seen
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | clr;

   assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
      $past(clr) |-> (q == '0))
      else $error("clear did not zero the register");

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!armed)
      (!clr && !valid) |=> $stable(q))
      else $error("register moved without valid");
endmodule

// File: rtl/crcp_engine.sv
module crcp_engine
   import crcp_pkg::*;
#(
   parameter int unsigned      CRC_W  = 16,
   parameter int unsigned      DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY   = 16'h8005
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              valid,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  fcs
);
   // Elaboration-time parameter checks
   generate
      if (!widths_legal(CRC_W, DATA_W)) begin : g_bad_width
         $error("DATA_W must be at least 1 and divide CRC_W");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("generator needs a constant term");
      end
   endgenerate

   logic [CRC_W-1:0] lane;
   logic [CRC_W-1:0] nxt;

   crcp_word_embed #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_embed (
      .word (data),
      .lane (lane)
   );

   crcp_next_state #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_next (
      .cur  (fcs),
      .lane (lane),
      .nxt  (nxt)
   );

   crcp_state_reg #(.CRC_W(CRC_W)) u_reg (
      .clk   (clk),
      .clr   (clr),
      .valid (valid),
      .nxt   (nxt),
      .q     (fcs)
   );

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | clr;

   // A word entering an all-zero register lands unchanged in the low bits
   assert_impulse_low_R4: assert property (@(posedge clk) disable iff (!armed)
      (!clr && valid && fcs == '0) |=> (fcs[DATA_W-1:0] == $past(data)))
      else $error("word did not land in the low state bits");

   assert_impulse_high_R4: assert property (@(posedge clk) disable iff (!armed)
      (!clr && valid && fcs == '0) |=> ((fcs >> DATA_W) == '0))
      else $error("word leaked into the upper state bits");

   // Zero state fed with zero words stays zero (linearity)
   assert_zero_fixed_R4: assert property (@(posedge clk) disable iff (!armed)
      (!clr && valid && data == '0 && fcs == '0) |=> (fcs == '0))
      else $error("zero state left on zero input");

   generate
      if (DATA_W == 1) begin : g_serial_chk
         assert_serial_tap0_R3: assert property (@(posedge clk)
            disable iff (!armed)
            (!clr && valid) |=> (fcs[0] == ($past(data[0]) ^ $past(fcs[CRC_W-1]))))
            else $error("bit 0 update wrong");
      end
   endgenerate
endmodule

// File: tb/crcp_engine_tb_top.sv
module crcp_engine_tb_top;
   localparam int CLK_P = 10;
   localparam logic [15:0] P16 = 16'h8005;
   localparam logic [15:0] PCC = 16'h1021;

   logic        clk = 1'b0;
   logic        clr, vld;
   logic [15:0] d16;
   logic [7:0]  d8;
   logic [0:0]  d1;
   logic [15:0] o_u16, o_u8, o_u1, o_c16, o_c8, o_c1;
   logic [3:0]  o_s4;

   always #(CLK_P/2) clk = ~clk;

   crcp_engine #(.CRC_W(16), .DATA_W(16), .POLY(P16)) dut_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d16), .fcs(o_u16));
   crcp_engine #(.CRC_W(16), .DATA_W(8), .POLY(P16)) dut_u8_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d8), .fcs(o_u8));
   crcp_engine #(.CRC_W(16), .DATA_W(1), .POLY(P16)) dut_u1_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d1), .fcs(o_u1));
   crcp_engine #(.CRC_W(16), .DATA_W(16), .POLY(PCC)) dut_c16_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d16), .fcs(o_c16));
   crcp_engine #(.CRC_W(16), .DATA_W(8), .POLY(PCC)) dut_c8_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d8), .fcs(o_c8));
   crcp_engine #(.CRC_W(16), .DATA_W(1), .POLY(PCC)) dut_c1_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d1), .fcs(o_c1));
   crcp_engine #(.CRC_W(4), .DATA_W(4), .POLY(4'b1001)) dut_s4_i (
      .clk(clk), .clr(clr), .valid(vld), .data(d16[3:0]), .fcs(o_s4));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [15:0] m_u16, m_u8, m_u1, m_c16, m_c8, m_c1;

   // Bit-serial reference step (R3 equations, POLY[0] = 1)
   function automatic logic [15:0] sstep(input logic [15:0] s, input logic d,
                                         input logic [15:0] p);
      return {s[14:0], d} ^ (s[15] ? p : 16'h0000);
   endfunction

   // n serial steps, bit n-1 of the word first
   function automatic logic [15:0] wstep(input logic [15:0] s, input logic [15:0] a,
                                         input int n, input logic [15:0] p);
      logic [15:0] t;
      t = s;
      for (int i = n - 1; i >= 0; i--) t = sstep(t, a[i], p);
      return t;
   endfunction

   task automatic chk(input string req, input string tag,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, tag, act, exp);
      end
   endtask

   // Drive one cycle at a falling edge, update the models, wait one cycle
   task automatic drive(input logic c, input logic v, input logic [15:0] a16,
                        input logic [7:0] a8, input logic a1);
      clr = c; vld = v; d16 = a16; d8 = a8; d1 = a1;
      if (c) begin
         m_u16 = '0; m_u8 = '0; m_u1 = '0; m_c16 = '0; m_c8 = '0; m_c1 = '0;
      end else if (v) begin
         m_u16 = wstep(m_u16, a16, 16, P16);
         m_c16 = wstep(m_c16, a16, 16, PCC);
         m_u8  = wstep(m_u8, {8'h00, a8}, 8, P16);
         m_c8  = wstep(m_c8, {8'h00, a8}, 8, PCC);
         m_u1  = wstep(m_u1, {15'h0, a1}, 1, P16);
         m_c1  = wstep(m_c1, {15'h0, a1}, 1, PCC);
      end
      @(negedge clk);
   endtask

   task automatic check_all(input string rw, input string rs);
      chk(rw, "u16", o_u16, m_u16);
      chk(rw, "c16", o_c16, m_c16);
      chk(rw, "u8",  o_u8,  m_u8);
      chk(rw, "c8",  o_c8,  m_c8);
      chk(rs, "u1",  o_u1,  m_u1);
      chk(rs, "c1",  o_c1,  m_c1);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] row15, row14, row13, crc;
      logic [3:0]  q3, q2, q1, q0;
      logic [15:0] words [4];
      void'($urandom(32'h00C0FFEE));
      clr = 1'b1; vld = 1'b0; d16 = '0; d8 = '0; d1 = '0;

      // R1: reset state
      drive(1, 0, 16'h0, 8'h0, 0);
      check_all("R1", "R1");
      chk("R1", "s4", {12'h0, o_s4}, 16'h0);

      // R4/R3: a few words, then R2: idle cycles with busy data
      for (int i = 0; i < 4; i++) begin
         drive(0, 1, 16'($urandom), 8'($urandom), 1'($urandom));
         check_all("R4", "R3");
      end
      for (int i = 0; i < 4; i++) begin
         drive(0, 0, 16'($urandom), 8'($urandom), 1'($urandom));
         check_all("R2", "R2");
      end

      // R1: clear while valid with all-ones data
      drive(1, 1, 16'hFFFF, 8'hFF, 1);
      check_all("R1", "R1");

      // R5 / R6: impulse response exposes matrix columns
      row15 = '0; row14 = '0; row13 = '0; q3 = '0; q2 = '0; q1 = '0; q0 = '0;
      for (int c = 0; c < 16; c++) begin
         drive(1, 0, 16'h0, 8'h0, 0);
         drive(0, 1, 16'h0001 << c, 8'h0, 0);
         drive(0, 1, 16'h0, 8'h0, 0);
         row15[c] = o_u16[15]; row14[c] = o_u16[14]; row13[c] = o_u16[13];
         if (c < 4) begin
            q3[c] = o_s4[3]; q2[c] = o_s4[2]; q1[c] = o_s4[1]; q0[c] = o_s4[0];
         end
      end
      chk("R5", "row x15", row15, 16'hDFFF);
      chk("R5", "row x14", row14, 16'h3000);
      chk("R5", "row x13", row13, 16'h1800);
      chk("R6", "row x3", {12'h0, q3}, 16'h0007);
      chk("R6", "row x2", {12'h0, q2}, 16'h000C);
      chk("R6", "row x1", {12'h0, q1}, 16'h000E);
      chk("R6", "row x0", {12'h0, q0}, 16'h000F);

      // R7: check string, byte-wide
      drive(1, 0, 16'h0, 8'h0, 0);
      for (int i = 0; i < 9; i++) drive(0, 1, 16'h0, 8'h31 + 8'(i), 0);
      for (int i = 0; i < 2; i++) drive(0, 1, 16'h0, 8'h00, 0);
      chk("R7", "u8 check string", o_u8, 16'hFEE8);
      chk("R7", "c8 check string", o_c8, 16'h31C3);

      // R7: check string, bit-serial
      drive(1, 0, 16'h0, 8'h0, 0);
      for (int i = 0; i < 9; i++) begin
         for (int b = 7; b >= 0; b--) drive(0, 1, 16'h0, 8'h0, (8'h31 + 8'(i)) >> b);
      end
      for (int i = 0; i < 16; i++) drive(0, 1, 16'h0, 8'h0, 0);
      chk("R7", "u1 check string", o_u1, 16'hFEE8);
      chk("R7", "c1 check string", o_c1, 16'h31C3);

      // R8: receiver pass, byte-wide
      drive(1, 0, 16'h0, 8'h0, 0);
      for (int i = 0; i < 9; i++) drive(0, 1, 16'h0, 8'h31 + 8'(i), 0);
      drive(0, 1, 16'h0, 8'h31, 0);
      drive(0, 1, 16'h0, 8'hC3, 0);
      chk("R8", "c8 receiver", o_c8, 16'h0000);

      // R8: receiver pass, word-wide, random message
      crc = '0;
      for (int i = 0; i < 4; i++) begin
         words[i] = 16'($urandom);
         crc = wstep(crc, words[i], 16, P16);
      end
      crc = wstep(crc, 16'h0, 16, P16);
      drive(1, 0, 16'h0, 8'h0, 0);
      for (int i = 0; i < 4; i++) drive(0, 1, words[i], 8'h0, 0);
      drive(0, 1, crc, 8'h0, 0);
      chk("R8", "u16 receiver", o_u16, 16'h0000);

      // Random streams against the serial model
      drive(1, 0, 16'h0, 8'h0, 0);
      for (int i = 0; i < 800; i++) begin
         drive(($urandom % 40) == 0, ($urandom % 4) != 0,
               16'($urandom), 8'($urandom), 1'($urandom));
         check_all("R4", "R3");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule